// File: doc/BRIEF.md
# Percussion Phase and Noise Generator

This block produces the substitute phases that drive three percussion voices of an FM synthesis engine when percussion mode is active. The hi-hat, snare and cymbal voices do not use their own phase accumulators directly. Their 10-bit phases are built from a few bits of two reference operator phases (the hi-hat operator and the cymbal operator), combined with one bit from a free-running noise shift register. The tom voice takes its own unmodulated phase, and the block only passes it through.

The noise source is a 23-bit shift register that starts from a fixed seed and moves one step per audio sample. The sample strobe marks each sample. On the same strobe the block registers all four output phases. The formulas use the noise bit that is present before the shift, so every sample sees one noise bit. Waveform lookup, envelope handling and percussion key-on decoding belong to neighbouring blocks.

Top module: `perc_phase_gen`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the noise register loads 0x306600 and all four phase outputs load zero.
- R2: On each strobed edge the noise register advances one step. If bit 0 is 1, the register is first XORed with the 24-bit mask 0x800302, where bit 23 lands in the top register bit. The result is then shifted right by one. `noise_bit_o` always equals bit 0 of `noise_state_o`.
- R3: When `sample_stb` is low, the noise register and all phase outputs keep their values, whatever the input phases do.
- R4: The shared metallic bit is M = hh[3] OR (hh[7] XOR hh[2]) OR (cy[5] XOR cy[3]), where hh and cy are the hi-hat and cymbal input phases. M appears in bit 9 of both the hi-hat and cymbal outputs.
- R5: The hi-hat output is (M << 9) OR (0x034 << S), where the 2-bit shift S = {N, M} and N is the noise bit.
- R6: The snare output is (0x100 << hh[8]) XOR (N << 8). Its value is therefore always 0x000, 0x100, 0x200 or 0x300.
- R7: The cymbal output is 0x100 OR (M << 9).
- R8: The tom output is the tom input phase, unchanged, captured on the strobe.
- R9: N is bit 0 of the noise register before the advance caused by that same strobe.
- R10: Outputs change on the rising edge that samples the strobe, and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sample_stb | input | 1 | One-cycle pulse per audio sample |
| hh_phase_i | input | 10 | Hi-hat operator phase (accumulator >> 9) |
| cy_phase_i | input | 10 | Cymbal operator phase (accumulator >> 9) |
| tom_phase_i | input | 10 | Tom operator phase |
| hh_phase_o | output | 10 | Derived hi-hat phase |
| sd_phase_o | output | 10 | Derived snare phase |
| cy_phase_o | output | 10 | Derived cymbal phase |
| tom_phase_o | output | 10 | Registered tom phase |
| noise_bit_o | output | 1 | Current noise bit (register bit 0) |
| noise_state_o | output | 23 | Noise register contents |

## Verification
Every result, both the four phases and the noise step, is due one rising edge after the strobe is sampled. The bench raises the strobe on a falling edge and reads the outputs on the next falling edge. It also looks once shortly after driving the strobe, to confirm that nothing has moved early. The expected noise bit is taken from the bench's own shift-register model before that model advances, which pins down which sample's bit feeds the formulas. Hold checks keep the strobe low for several cycles while the inputs change, and compare the outputs on every falling edge.

// File: rtl/perc_pkg.sv
// Shared constants and types for the percussion phase generator.
// Assumes 10-bit operator phases; bit positions below are fixed by the
// percussion formulas and are not meant to be retuned.
package perc_pkg;
    localparam int PH_W = 10;
    typedef logic [PH_W-1:0] phase_t;

    // Bit positions used for the metallic bit
    localparam int HH_OR_BIT  = 3;
    localparam int HH_XA_BIT  = 7;
    localparam int HH_XB_BIT  = 2;
    localparam int CY_XA_BIT  = 5;
    localparam int CY_XB_BIT  = 3;
    localparam int HH_SEL_BIT = 8;

    // Base patterns for the derived phases
    localparam phase_t HH_BASE  = 10'h034;
    localparam phase_t SD_BASE  = 10'h100;
    localparam phase_t CY_BASE  = 10'h100;
    localparam int     TOP_BIT  = PH_W - 1;
    localparam int     NZ_SHIFT = 8;
endpackage

// File: rtl/perc_noise_lfsr.sv
// Noise shift register: one step per strobe, XOR with FB_MASK when bit 0 is
// set, then shift right. Assumes FB_MASK bit W is set so bit 0 feeds the top.
module perc_noise_lfsr #(
    parameter int           W       = 23,
    parameter logic [W-1:0] SEED    = 23'h306600,
    parameter logic [W:0]   FB_MASK = 24'h800302
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         adv,
    output logic [W-1:0] state_o
);
    logic [W:0] mixed;

    // Next-state value: conditional feedback XOR on the widened register
    always_comb begin
        mixed = {1'b0, state_o} ^ (state_o[0] ? FB_MASK : '0);
    end

    // Register: seed on reset, step on strobe, hold otherwise
    always_ff @(posedge clk) begin
        if (!rst_n)   state_o <= SEED;
        else if (adv) state_o <= mixed[W:1];
    end

    // R2: old bit 0 reappears at the top after a step
    a_r2_top_from_bit0: assert property (@(posedge clk) disable iff (!rst_n)
        adv |=> state_o[W-1] == $past(state_o[0]));

    // R3: no step without a strobe
    a_r3_noise_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(state_o));
endmodule

// File: rtl/perc_metal_bit.sv
// Metallic bit shared by hi-hat and cymbal: combinational, from fixed bits
// of the two reference phases.
module perc_metal_bit
    import perc_pkg::*;
(
    input  phase_t hh_ph,
    input  phase_t cy_ph,
    output logic   metal
);
    // OR of one hi-hat bit with two XOR pairs
    always_comb begin
        metal = hh_ph[HH_OR_BIT]
              | (hh_ph[HH_XA_BIT] ^ hh_ph[HH_XB_BIT])
              | (cy_ph[CY_XA_BIT] ^ cy_ph[CY_XB_BIT]);
    end
endmodule

// File: rtl/perc_phase_mix.sv
// Builds hi-hat, snare and cymbal phases from the metallic bit, the noise
// bit and hi-hat bit 8. Purely combinational; the caller registers.
module perc_phase_mix
    import perc_pkg::*;
(
    input  logic   metal,
    input  logic   nz,
    input  logic   hh_sel,
    output phase_t hh_ph,
    output phase_t sd_ph,
    output phase_t cy_ph
);
    logic [1:0] hh_shift;

    // Hi-hat shift amount is {noise, metal}
    always_comb hh_shift = {nz, metal};

    // Phase formulas
    always_comb begin
        hh_ph = (phase_t'(metal) << TOP_BIT) | (HH_BASE << hh_shift);
        sd_ph = (SD_BASE << hh_sel) ^ (phase_t'(nz) << NZ_SHIFT);
        cy_ph = CY_BASE | (phase_t'(metal) << TOP_BIT);
    end
endmodule

// File: rtl/perc_phase_gen.sv
// Top: percussion phase generator. Registers the derived phases and the tom
// phase on each sample strobe, using the noise bit present before the same
// strobe advances the noise register. Assumes one strobe per sample.
module perc_phase_gen
    import perc_pkg::*;
#(
    parameter int                 NOISE_W    = 23,
    parameter logic [NOISE_W-1:0] NOISE_SEED = 23'h306600,
    parameter logic [NOISE_W:0]   NOISE_MASK = 24'h800302
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sample_stb,
    input  logic [9:0]         hh_phase_i,
    input  logic [9:0]         cy_phase_i,
    input  logic [9:0]         tom_phase_i,
    output logic [9:0]         hh_phase_o,
    output logic [9:0]         sd_phase_o,
    output logic [9:0]         cy_phase_o,
    output logic [9:0]         tom_phase_o,
    output logic               noise_bit_o,
    output logic [NOISE_W-1:0] noise_state_o
);
    logic   metal;
    phase_t hh_d, sd_d, cy_d;

    perc_noise_lfsr #(
        .W       (NOISE_W),
        .SEED    (NOISE_SEED),
        .FB_MASK (NOISE_MASK)
    ) i_noise (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv     (sample_stb),
        .state_o (noise_state_o)
    );

    perc_metal_bit i_metal (
        .hh_ph (hh_phase_i),
        .cy_ph (cy_phase_i),
        .metal (metal)
    );

    perc_phase_mix i_mix (
        .metal  (metal),
        .nz     (noise_state_o[0]),
        .hh_sel (hh_phase_i[HH_SEL_BIT]),
        .hh_ph  (hh_d),
        .sd_ph  (sd_d),
        .cy_ph  (cy_d)
    );

    // Current noise bit straight from the register
    always_comb noise_bit_o = noise_state_o[0];

    // Output registers: clear on reset, capture on strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hh_phase_o  <= '0;
            sd_phase_o  <= '0;
            cy_phase_o  <= '0;
            tom_phase_o <= '0;
        end else if (sample_stb) begin
            hh_phase_o  <= hh_d;
            sd_phase_o  <= sd_d;
            cy_phase_o  <= cy_d;
            tom_phase_o <= tom_phase_i;
        end
    end

    // R5: hi-hat pattern below bit 9 always has exactly three ones
    a_r5_hh_shape: assert property (@(posedge clk) disable iff (!rst_n)
        sample_stb |=> $countones(hh_phase_o[8:0]) == 3);

    // R6: snare low byte is always clear
    a_r6_sd_low_clear: assert property (@(posedge clk) disable iff (!rst_n)
        sample_stb |=> sd_phase_o[7:0] == 8'h00);

    // R7 and R4: cymbal low part fixed, metallic bit shared with hi-hat
    a_r7_cy_shape: assert property (@(posedge clk) disable iff (!rst_n)
        sample_stb |=> (cy_phase_o[8:0] == 9'h100) && (cy_phase_o[9] == hh_phase_o[9]));

    // R8: tom phase captured unchanged
    a_r8_tom_pass: assert property (@(posedge clk) disable iff (!rst_n)
        sample_stb |=> tom_phase_o == $past(tom_phase_i));

    // R3: phase outputs hold without a strobe
    a_r3_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_stb |=> $stable(hh_phase_o) && $stable(sd_phase_o)
                        && $stable(cy_phase_o) && $stable(tom_phase_o));
endmodule

// File: tb/test_perc_phase_gen.sv
module test_perc_phase_gen;
    import perc_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        sample_stb;
    logic [9:0]  hh_in, cy_in, tom_in;
    logic [9:0]  hh_out, sd_out, cy_out, tom_out;
    logic        noise_bit;
    logic [22:0] noise_st;

    int checks = 0;
    int errors = 0;
    logic [22:0] m_noise;

    always #4 clk = ~clk;

    perc_phase_gen i_perc_phase_gen (
        .clk           (clk),
        .rst_n         (rst_n),
        .sample_stb    (sample_stb),
        .hh_phase_i    (hh_in),
        .cy_phase_i    (cy_in),
        .tom_phase_i   (tom_in),
        .hh_phase_o    (hh_out),
        .sd_phase_o    (sd_out),
        .cy_phase_o    (cy_out),
        .tom_phase_o   (tom_out),
        .noise_bit_o   (noise_bit),
        .noise_state_o (noise_st)
    );

    // {hh phase, cymbal phase, expected metallic bit}
    localparam logic [20:0] VEC [0:8] = '{
        {10'h000, 10'h000, 1'b0},
        {10'h008, 10'h000, 1'b1},
        {10'h080, 10'h000, 1'b1},
        {10'h084, 10'h000, 1'b0},
        {10'h000, 10'h020, 1'b1},
        {10'h000, 10'h028, 1'b0},
        {10'h104, 10'h000, 1'b1},
        {10'h3F7, 10'h3FF, 1'b0},
        {10'h300, 10'h008, 1'b1}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [22:0] m_next(input logic [22:0] s);
        logic [23:0] t;
        t = {1'b0, s} ^ (s[0] ? 24'h800302 : 24'h0);
        return t[23:1];
    endfunction

    function automatic logic ref_metal(input logic [9:0] h, input logic [9:0] c);
        return h[3] | (h[7] ^ h[2]) | (c[5] ^ c[3]);
    endfunction

    function automatic logic [9:0] exp_hh(input logic m, input logic n);
        logic [9:0] b;
        b = 10'h034 << {n, m};
        return {m, 9'h000} | b;
    endfunction

    function automatic logic [9:0] exp_sd(input logic h8, input logic n);
        return (10'h100 << h8) ^ {1'b0, n, 8'h00};
    endfunction

    // One strobed sample with full output comparison one edge later
    task automatic do_sample(input logic [9:0] h, input logic [9:0] c,
                             input logic [9:0] t, input logic m);
        logic n0;
        @(negedge clk);
        hh_in = h; cy_in = c; tom_in = t; sample_stb = 1'b1;
        n0 = m_noise[0];
        @(negedge clk);
        sample_stb = 1'b0;
        m_noise = m_next(m_noise);
        check("R4 metallic bit", {31'd0, cy_out[9]}, {31'd0, m});
        check("R5 R9 hi-hat phase", {22'd0, hh_out}, {22'd0, exp_hh(m, n0)});
        check("R6 R9 snare phase", {22'd0, sd_out}, {22'd0, exp_sd(h[8], n0)});
        check("R7 cymbal phase", {22'd0, cy_out}, {22'd0, {m, 9'h100}});
        check("R8 tom phase", {22'd0, tom_out}, {22'd0, t});
        check("R2 noise state", {9'd0, noise_st}, {9'd0, m_noise});
        check("R2 noise bit", {31'd0, noise_bit}, {31'd0, m_noise[0]});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [9:0] sh, ss, sc, st;
        logic [22:0] sn;
        rst_n = 1'b0; sample_stb = 1'b0;
        hh_in = '0; cy_in = '0; tom_in = '0;
        m_noise = 23'h306600;
        repeat (3) @(negedge clk);

        // R1: reset state
        check("R1 noise seed", {9'd0, noise_st}, 32'h306600);
        check("R1 hi-hat zero", {22'd0, hh_out}, 32'h0);
        check("R1 snare zero", {22'd0, sd_out}, 32'h0);
        check("R1 cymbal zero", {22'd0, cy_out}, 32'h0);
        check("R1 tom zero", {22'd0, tom_out}, 32'h0);
        rst_n = 1'b1;

        // Table walk (R4..R8)
        for (int i = 0; i < 9; i++) begin
            do_sample(VEC[i][20:11], VEC[i][10:1], 10'(i * 37), VEC[i][0]);
        end

        // R10: nothing moves before the sampling edge
        @(negedge clk);
        sh = tom_out;
        tom_in = ~sh; hh_in = 10'h008; sample_stb = 1'b1;
        #2;
        check("R10 no early change", {22'd0, tom_out}, {22'd0, sh});
        @(negedge clk);
        sample_stb = 1'b0;
        m_noise = m_next(m_noise);
        check("R10 change after one edge", {22'd0, tom_out}, {22'd0, ~sh});

        // R3: hold without strobe while inputs toggle
        sh = hh_out; ss = sd_out; sc = cy_out; st = tom_out; sn = noise_st;
        for (int k = 0; k < 6; k++) begin
            hh_in = 10'($urandom); cy_in = 10'($urandom); tom_in = 10'($urandom);
            @(negedge clk);
            check("R3 hi-hat hold", {22'd0, hh_out}, {22'd0, sh});
            check("R3 snare hold", {22'd0, sd_out}, {22'd0, ss});
            check("R3 cymbal hold", {22'd0, cy_out}, {22'd0, sc});
            check("R3 tom hold", {22'd0, tom_out}, {22'd0, st});
            check("R3 noise hold", {9'd0, noise_st}, {9'd0, sn});
        end

        // Long random run: noise sequence and all formulas (R2, R4..R9)
        for (int k = 0; k < 1500; k++) begin
            logic [9:0] rh, rc, rt;
            rh = 10'($urandom); rc = 10'($urandom); rt = 10'($urandom);
            do_sample(rh, rc, rt, ref_metal(rh, rc));
        end

        // R1: reset in mid-run overrides a strobe
        @(negedge clk);
        rst_n = 1'b0; sample_stb = 1'b1;
        @(negedge clk);
        @(negedge clk);
        sample_stb = 1'b0;
        check("R1 mid-run reset seed", {9'd0, noise_st}, 32'h306600);
        check("R1 mid-run reset hi-hat", {22'd0, hh_out}, 32'h0);
        rst_n = 1'b1;
        m_noise = 23'h306600;
        do_sample(10'h084, 10'h028, 10'h155, 1'b0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule